// File: doc/BRIEF.md
# BCD Time Set Adjuster

This block holds the two editable time words of a wall-clock subsystem: the clock-set copy and the alarm time. Both are packed BCD words. Bits [23:16] hold the hours, bits [15:8] the minutes and bits [7:0] the seconds, with the tens digit in the upper nibble of each pair. A two-bit mode input chooses which word, if any, is being edited. A position flag chooses whether the minute pair or the hour pair responds to the up and down keys.

Edits are applied only on a slow repeat tick, which is a one-cycle pulse supplied from outside at roughly 10 Hz. A key held down therefore steps the field once per tick. Each field wraps on its own in both directions and never carries into or borrows from its neighbour. The seconds pair is never edited.

While the clock-set mode is not selected, the clock-set copy follows the live time on every cycle. Editing therefore always starts from the current time, and the running clock can load the result when setting ends. The alarm word holds its value whenever the alarm-set mode is not selected.

Top module: `bcd_time_setter`

## Requirements
- R1: After reset, the clock-set copy and the alarm word are 00:00:00 and the position flag is 0, which selects hours.
- R2: While the mode is not 2'b10, the clock-set output equals the live time input sampled one clock earlier.
- R3: A key_pos_i pulse inverts the position flag one cycle later, but only when the mode is 2'b10 or 2'b11. In any other mode the pulse has no effect.
- R4: Stepping minutes up (flag 1, key_up_i) turns 59 into 00, moves units 9 to 0 with the tens digit plus one, and otherwise adds one to the units digit.
- R5: Stepping minutes down turns 00 into 59, turns a units digit of 0 with a nonzero tens digit into tens minus one with units 9, and otherwise subtracts one from the units digit.
- R6: Stepping hours up (flag 0) turns 23 into 00, and units 9 carries into the tens digit.
- R7: Stepping hours down maps 00 to 23, 10 to 09 and 20 to 19, and otherwise subtracts one from the units digit.
- R8: An edit takes effect one cycle after a cycle in which tick_i and a key are both high. A held key without a tick, or a tick without a key, leaves the word unchanged.
- R9: If key_up_i and key_dn_i are both high on a tick, the field steps up.
- R10: Mode 2'b11 applies the same edits to the alarm word, and the alarm word holds its value in all other modes.
- R11: The seconds pair and the field that is not selected never change through an edit. No edit ever carries into or borrows from the neighbouring field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_i | input | 2 | 2'b10 selects clock-set editing, 2'b11 selects alarm editing |
| live_time_i | input | 24 | Live BCD time from the running clock |
| tick_i | input | 1 | Repeat tick, one-cycle pulse |
| key_up_i | input | 1 | Increment key level |
| key_dn_i | input | 1 | Decrement key level |
| key_pos_i | input | 1 | Position-toggle pulse |
| set_time_o | output | 24 | Clock-set BCD word |
| alarm_time_o | output | 24 | Alarm BCD word |
| field_sel_o | output | 1 | Position flag: 1 selects minutes, 0 selects hours |

## Verification
A wrong wrap or borrow in a pair stepper shows up in the affected field one cycle after the tick, for example as a non-BCD nibble, a 60 or a 24. It can also show up as a change in the neighbouring field, so the whole 24-bit word is compared after each step. Every minute and hour value is swept in both directions from a word loaded through the live input. A tracking or clock-enable fault shows up one cycle after the mode or tick input changes. It appears either as a stale clock-set copy or as a word that moves without a tick or in the wrong mode.

// File: rtl/bcd_set_pkg.sv
package bcd_set_pkg;
  localparam int DIGIT_W = 4;
  localparam int PAIR_W  = 2 * DIGIT_W;
  localparam int TIME_W  = 3 * PAIR_W;

  typedef logic [PAIR_W-1:0] bcd_pair_t;
  typedef logic [TIME_W-1:0] bcd_time_t;

  // Pair positions inside a packed time word
  localparam int SEC_LSB  = 0;
  localparam int MIN_LSB  = PAIR_W;
  localparam int HOUR_LSB = 2 * PAIR_W;

  localparam bcd_pair_t MIN_LIMIT  = 8'h59;
  localparam bcd_pair_t HOUR_LIMIT = 8'h23;
endpackage

// File: rtl/bcd_rst_sync.sv
module bcd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/bcd_pair_step.sv
module bcd_pair_step
  import bcd_set_pkg::*;
#(
  parameter bcd_pair_t LIMIT = 8'h59
) (
  input  bcd_pair_t val_i,
  output bcd_pair_t inc_o,
  output bcd_pair_t dec_o
);
  logic [DIGIT_W-1:0] units, tens;
  localparam logic [DIGIT_W-1:0] NINE = DIGIT_W'(9);
  localparam logic [DIGIT_W-1:0] ONE  = DIGIT_W'(1);

  assign units = val_i[DIGIT_W-1:0];
  assign tens  = val_i[PAIR_W-1:DIGIT_W];

  always_comb begin
    if (val_i == LIMIT)     inc_o = '0;
    else if (units == NINE) inc_o = {tens + ONE, {DIGIT_W{1'b0}}};
    else                    inc_o = {tens, units + ONE};

    if (val_i == '0)             dec_o = LIMIT;
    else if (units == '0)        dec_o = {tens - ONE, NINE};
    else                         dec_o = {tens, units - ONE};
  end
endmodule

// File: rtl/bcd_time_edit.sv
module bcd_time_edit
  import bcd_set_pkg::*;
#(
  parameter bit TRACK = 1'b1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      edit_en_i,
  input  logic      tick_i,
  input  logic      up_i,
  input  logic      dn_i,
  input  logic      min_sel_i,
  input  bcd_time_t live_i,
  output bcd_time_t word_o
);
  bcd_time_t word_q, word_d;
  bcd_pair_t min_inc, min_dec, hour_inc, hour_dec;
  logic      track_ce, edit_ce, word_ce;

  bcd_pair_step #(.LIMIT(MIN_LIMIT)) u_min_step (
    .val_i (word_q[MIN_LSB +: PAIR_W]),
    .inc_o (min_inc),
    .dec_o (min_dec)
  );

  bcd_pair_step #(.LIMIT(HOUR_LIMIT)) u_hour_step (
    .val_i (word_q[HOUR_LSB +: PAIR_W]),
    .inc_o (hour_inc),
    .dec_o (hour_dec)
  );

  assign track_ce = TRACK && !edit_en_i;
  assign edit_ce  = edit_en_i && tick_i && (up_i || dn_i);
  assign word_ce  = track_ce || edit_ce;

  always_comb begin
    word_d = word_q;
    if (track_ce) begin
      word_d = live_i;
    end else if (min_sel_i) begin
      word_d[MIN_LSB +: PAIR_W] = up_i ? min_inc : min_dec;
    end else begin
      word_d[HOUR_LSB +: PAIR_W] = up_i ? hour_inc : hour_dec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (word_ce) word_q <= word_d;
  end

  assign word_o = word_q;
endmodule

// File: rtl/bcd_time_setter.sv
module bcd_time_setter
  import bcd_set_pkg::*;
#(
  parameter logic [1:0] MODE_CLK_SET = 2'b10,
  parameter logic [1:0] MODE_ALM_SET = 2'b11,
  parameter int         SYNC_STAGES  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  mode_i,
  input  logic [23:0] live_time_i,
  input  logic        tick_i,
  input  logic        key_up_i,
  input  logic        key_dn_i,
  input  logic        key_pos_i,
  output logic [23:0] set_time_o,
  output logic [23:0] alarm_time_o,
  output logic        field_sel_o
);
  localparam int N_WORDS = 2;

  logic      rst_int_n;
  logic      pos_q, pos_d, pos_ce;
  logic      in_setting;
  bcd_time_t words [N_WORDS];

  bcd_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  assign in_setting = (mode_i == MODE_CLK_SET) || (mode_i == MODE_ALM_SET);
  assign pos_ce     = in_setting && key_pos_i;
  assign pos_d      = ~pos_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  pos_q <= 1'b0;
    else if (pos_ce) pos_q <= pos_d;
  end

  // Word 0 is the clock-set copy (tracks live time), word 1 the alarm
  for (genvar g = 0; g < N_WORDS; g++) begin : g_word
    localparam logic [1:0] MY_MODE = (g == 0) ? MODE_CLK_SET : MODE_ALM_SET;
    bcd_time_edit #(.TRACK(g == 0)) u_edit (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .edit_en_i (mode_i == MY_MODE),
      .tick_i    (tick_i),
      .up_i      (key_up_i),
      .dn_i      (key_dn_i),
      .min_sel_i (pos_q),
      .live_i    (live_time_i),
      .word_o    (words[g])
    );
  end

  assign set_time_o   = words[0];
  assign alarm_time_o = words[1];
  assign field_sel_o  = pos_q;
endmodule

// File: rtl/bcd_time_setter_chk.sv
module bcd_time_setter_chk (
  input logic        clk,
  input logic        rst_ok,
  input logic [1:0]  mode_i,
  input logic [23:0] live_time_i,
  input logic        tick_i,
  input logic        key_up_i,
  input logic        key_dn_i,
  input logic        key_pos_i,
  input logic [23:0] set_time_o,
  input logic [23:0] alarm_time_o,
  input logic        field_sel_o
);
  // R2: clock-set copy follows live time outside clock-set mode
  a_r2_track_live: assert property (@(posedge clk) disable iff (!rst_ok)
    (mode_i != 2'b10) |=> (set_time_o == $past(live_time_i)));

  // R3: flag frozen outside the setting modes
  a_r3_flag_frozen: assert property (@(posedge clk) disable iff (!rst_ok)
    (mode_i[1] == 1'b0) |=> $stable(field_sel_o));

  // R3: flag inverts on a toggle pulse inside a setting mode
  a_r3_flag_toggles: assert property (@(posedge clk) disable iff (!rst_ok)
    (mode_i[1] && key_pos_i) |=> (field_sel_o != $past(field_sel_o)));

  // R8: no movement of the word being edited without tick and key
  a_r8_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_ok)
    ((mode_i == 2'b10) && !(tick_i && (key_up_i || key_dn_i))) |=> $stable(set_time_o));

  // R10: alarm word holds outside alarm-set mode
  a_r10_alarm_hold: assert property (@(posedge clk) disable iff (!rst_ok)
    (mode_i != 2'b11) |=> $stable(alarm_time_o));

  // R11: seconds untouched while editing
  a_r11_seconds_kept: assert property (@(posedge clk) disable iff (!rst_ok)
    (mode_i == 2'b10) |=> (set_time_o[7:0] == $past(set_time_o[7:0])));

  // R4 R6: alarm fields stay legal BCD in range
  a_r4_alarm_legal: assert property (@(posedge clk) disable iff (!rst_ok)
    (alarm_time_o[15:8] <= 8'h59) && (alarm_time_o[11:8] <= 4'd9) &&
    (alarm_time_o[23:16] <= 8'h23) && (alarm_time_o[19:16] <= 4'd9));
endmodule

bind bcd_time_setter bcd_time_setter_chk u_chk (
  .clk          (clk),
  .rst_ok       (rst_int_n),
  .mode_i       (mode_i),
  .live_time_i  (live_time_i),
  .tick_i       (tick_i),
  .key_up_i     (key_up_i),
  .key_dn_i     (key_dn_i),
  .key_pos_i    (key_pos_i),
  .set_time_o   (set_time_o),
  .alarm_time_o (alarm_time_o),
  .field_sel_o  (field_sel_o)
);

// File: tb/bcd_time_setter_bench.sv
module bcd_time_setter_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode_i;
  logic [23:0] live_time_i;
  logic        tick_i, key_up_i, key_dn_i, key_pos_i;
  logic [23:0] set_time_o, alarm_time_o;
  logic        field_sel_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bcd_time_setter u_bcd_time_setter (
    .clk (clk), .rst_n (rst_n), .mode_i (mode_i), .live_time_i (live_time_i),
    .tick_i (tick_i), .key_up_i (key_up_i), .key_dn_i (key_dn_i),
    .key_pos_i (key_pos_i), .set_time_o (set_time_o),
    .alarm_time_o (alarm_time_o), .field_sel_o (field_sel_o)
  );

  function automatic logic [7:0] to_bcd(int n);
    return {4'(n / 10), 4'(n % 10)};
  endfunction

  task automatic check(string req, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_clock(logic [23:0] t);
    mode_i = 2'b00; live_time_i = t;
    @(negedge clk);
    mode_i = 2'b10;
  endtask

  task automatic step(logic up, logic dn);
    tick_i = 1'b1; key_up_i = up; key_dn_i = dn;
    @(negedge clk);
    tick_i = 1'b0; key_up_i = 1'b0; key_dn_i = 1'b0;
  endtask

  task automatic pulse_pos();
    key_pos_i = 1'b1;
    @(negedge clk);
    key_pos_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [23:0] t;
    int h;
    rst_n = 1'b0; mode_i = 2'b00; live_time_i = '0;
    tick_i = 1'b0; key_up_i = 1'b0; key_dn_i = 1'b0; key_pos_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 set", set_time_o, 24'h000000);
    check("R1 alarm", alarm_time_o, 24'h000000);
    check("R1 flag", {23'd0, field_sel_o}, 24'd0);

    // R2 tracking
    live_time_i = 24'h123456; @(negedge clk);
    check("R2 track", set_time_o, 24'h123456);
    live_time_i = 24'h235959; @(negedge clk);
    check("R2 track", set_time_o, 24'h235959);

    // R3 toggle ignored in run mode, effective in set mode
    pulse_pos();
    check("R3 ignored", {23'd0, field_sel_o}, 24'd0);
    mode_i = 2'b01; pulse_pos();
    check("R3 ignored mode01", {23'd0, field_sel_o}, 24'd0);
    mode_i = 2'b10; pulse_pos();
    check("R3 toggle", {23'd0, field_sel_o}, 24'd1);

    // R4 R11 minute up sweep
    for (int m = 0; m < 60; m++) begin
      t = {8'h07, to_bcd(m), 8'h42};
      load_clock(t); step(1'b1, 1'b0);
      check("R4 min up", set_time_o, {8'h07, to_bcd((m + 1) % 60), 8'h42});
    end
    // R5 R11 minute down sweep
    for (int m = 0; m < 60; m++) begin
      t = {8'h19, to_bcd(m), 8'h08};
      load_clock(t); step(1'b0, 1'b1);
      check("R5 min down", set_time_o, {8'h19, to_bcd((m + 59) % 60), 8'h08});
    end

    pulse_pos();
    check("R3 toggle back", {23'd0, field_sel_o}, 24'd0);

    // R6 hour up sweep
    for (int hh = 0; hh < 24; hh++) begin
      t = {to_bcd(hh), 8'h59, 8'h33};
      load_clock(t); step(1'b1, 1'b0);
      check("R6 hour up", set_time_o, {to_bcd((hh + 1) % 24), 8'h59, 8'h33});
    end
    // R7 hour down sweep
    for (int hh = 0; hh < 24; hh++) begin
      t = {to_bcd(hh), 8'h00, 8'h01};
      load_clock(t); step(1'b0, 1'b1);
      check("R7 hour down", set_time_o, {to_bcd((hh + 23) % 24), 8'h00, 8'h01});
    end

    // R8 key without tick, tick without key
    load_clock(24'h112233);
    key_up_i = 1'b1; repeat (3) @(negedge clk); key_up_i = 1'b0;
    check("R8 no tick", set_time_o, 24'h112233);
    step(1'b0, 1'b0);
    check("R8 no key", set_time_o, 24'h112233);
    live_time_i = 24'h000000; @(negedge clk);
    check("R8 no track in set", set_time_o, 24'h112233);

    // R9 both keys: up wins
    step(1'b1, 1'b1);
    check("R9 both keys", set_time_o, 24'h122233);

    // R10 alarm editing, hour field
    mode_i = 2'b11; live_time_i = 24'h010203; @(negedge clk);
    check("R10 set tracks in alarm mode", set_time_o, 24'h010203);
    check("R10 alarm start", alarm_time_o, 24'h000000);
    h = 0;
    for (int k = 0; k < 25; k++) begin
      step(1'b1, 1'b0);
      h = (h + 1) % 24;
      check("R10 alarm hour up", alarm_time_o, {to_bcd(h), 16'h0000});
    end
    pulse_pos();
    check("R3 toggle alarm mode", {23'd0, field_sel_o}, 24'd1);
    step(1'b0, 1'b1);
    check("R10 alarm min down", alarm_time_o, {to_bcd(h), 8'h59, 8'h00});

    // R10 alarm holds in other modes
    mode_i = 2'b10; step(1'b1, 1'b0);
    check("R10 alarm hold mode10", alarm_time_o, {to_bcd(h), 8'h59, 8'h00});
    mode_i = 2'b00; step(1'b0, 1'b1);
    check("R10 alarm hold mode00", alarm_time_o, {to_bcd(h), 8'h59, 8'h00});

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule